// File: doc/BRIEF.md
# Hysteretic Window Switching Controller

This block is the digital core of a synchronous inductor converter. It drives the enables of the high-side and the low-side power switch and reads nothing but comparator flags: the output is above the upper window limit, the output is below the lower window limit, the switch current is over its limit, the inductor current has reached zero, and the converter input is below the target output. It does not compute a duty cycle from an error voltage. Each switching period has four phases: a dead gap, a charging ramp, a second dead gap and a rectifying ramp. The controller reads the window flags only when the rectifying ramp ends, and that reading sets the next period.

When the load is heavy the controller runs in continuous mode. It repeats a fixed period and keeps a learned on-time, which it moves up or down one step per period. When the output drops below the window, the next charging ramp is lengthened. When the load is light the controller falls back to a pulse-on-demand mode: it fires a single pulse of the learned on-time each time the output sinks below the upper limit. An external force input keeps the controller in continuous mode, and that input may be held high or toggled as a clock. In down-conversion, when the input is below the target, the high-side switch stays on without a break.

Top module: `window_switch_ctrl`

## Requirements
- R1: `hs_gate_o` and `ls_gate_o` are never high together. A gate never rises in the cycle directly after the other gate was high, so at least one cycle with both low separates every handover.
- R2: During reset both gates are low. After reset the controller is in continuous mode (`mode_cont_o`=1) and has an on-time of 6. With all flags low, a period lasts 22 clocks and the charging pulse lasts exactly the on-time.
- R3: If `below_lo_i` is high when a rectifying ramp ends, the on-time goes up by one and the next charging pulse is the new on-time plus 8. The period after that is back to normal length.
- R4: If `over_cur_i` is high during a charging cycle, the charging gate is low in the next cycle and the controller moves on to the dead gap and then the rectifier.
- R5: If `zero_cur_i` is high during a rectifier cycle, the rectifier gate is low in the next cycle. It stays low until the next charging phase.
- R6: If `above_hi_i` is high when a continuous-mode ramp ends, the on-time goes down by one. The on-time always stays between 2 and 16.
- R7: Four decisions in a row in continuous mode with `above_hi_i` high put the controller in pulse-on-demand mode (`mode_cont_o`=0). In that mode no gate switches while `above_hi_i` is high. While `above_hi_i` is low, the controller fires pulses of the frozen on-time and ends each rectifier phase at zero current. A decision in that mode with `below_lo_i` high returns the controller to continuous mode.
- R8: While `force_cont_i` is high, or has been high within the last 22 clocks after a two-flop synchroniser, the controller stays in continuous mode. Any number of above-limit decisions does not change that.
- R9: If `down_sel_i`=1 and `vin_low_i`=1 at a decision, `hs_gate_o` is held high and `ls_gate_o` is held low until `vin_low_i` falls. The controller then continues with a dead gap and a rectifier phase.
- R10: When `down_sel_i`=0 (up), `ls_gate_o` charges and `hs_gate_o` rectifies. When `down_sel_i`=1 (down), `hs_gate_o` charges and `ls_gate_o` rectifies. The select is sampled only at decisions, and with an on-time of N the rectifier phase of a normal period lasts 20-N clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | controller clock |
| rst_n | input | 1 | asynchronous active-low reset |
| force_cont_i | input | 1 | force continuous mode; level or external clock |
| down_sel_i | input | 1 | 0 = up-conversion, 1 = down-conversion |
| above_hi_i | input | 1 | output above upper window limit |
| below_lo_i | input | 1 | output below lower window limit |
| over_cur_i | input | 1 | switch current over limit |
| zero_cur_i | input | 1 | inductor current has reached zero |
| vin_low_i | input | 1 | input below target output |
| hs_gate_o | output | 1 | high-side switch enable |
| ls_gate_o | output | 1 | low-side switch enable |
| mode_cont_o | output | 1 | 1 = continuous mode, 0 = pulse-on-demand |

## Verification
The assertions assume that the comparator flags are already synchronous to the clock and that `above_hi_i` and `below_lo_i` are never high together. Only the force input is taken as asynchronous. The stimulus changes flags only at falling clock edges, and it keeps the two window flags exclusive. Most changes are made just after a charging pulse ends, so that the next decision sees a stable level and the expected pulse width is known in advance.

// File: rtl/window_switch_ctrl.sv
module window_switch_ctrl #(
  parameter int PERIOD       = 22,
  parameter int ON_MIN       = 2,
  parameter int ON_MAX       = 16,
  parameter int ON_INIT      = 6,
  parameter int STRETCH      = 8,
  parameter int FALLBACK_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic force_cont_i,
  input  logic down_sel_i,
  input  logic above_hi_i,
  input  logic below_lo_i,
  input  logic over_cur_i,
  input  logic zero_cur_i,
  input  logic vin_low_i,
  output logic hs_gate_o,
  output logic ls_gate_o,
  output logic mode_cont_o
);
  localparam int CW = $clog2(PERIOD + STRETCH + 1);
  localparam int FW = $clog2(PERIOD + 1);
  localparam int HW = $clog2(FALLBACK_CNT + 1);
  localparam logic [CW-1:0] P_LAST   = CW'(PERIOD - 1);
  localparam logic [CW-1:0] P_LAST_S = CW'(PERIOD - 1 + STRETCH);
  localparam logic [CW-1:0] ONMN     = CW'(ON_MIN);
  localparam logic [CW-1:0] ONMX     = CW'(ON_MAX);
  localparam logic [CW-1:0] ONIN     = CW'(ON_INIT);
  localparam logic [CW-1:0] STR      = CW'(STRETCH);
  localparam logic [FW-1:0] FRLD     = FW'(PERIOD);
  localparam logic [HW-1:0] HLIM     = HW'(FALLBACK_CNT);

  typedef enum logic [2:0] {S_IDLE, S_DEADA, S_CHG, S_DEADB, S_RECT, S_WAIT, S_HOLD} st_t;

  st_t           st;
  logic [CW-1:0] pcnt, chg_len, plen, on_t;
  logic [HW-1:0] hi_cnt;
  logic [FW-1:0] frc_cnt;
  logic [1:0]    fsync;
  logic          mode_q, dir_q, hold_q;

  logic          force_act, decide, fall, mode_nx, hold_nx, stretch, chg_on, rect_on;
  logic [CW-1:0] on_up, on_dn, on_nx;
  logic [HW-1:0] hi_sat;

  assign force_act = fsync[1] | (frc_cnt != '0);
  assign decide    = (st == S_RECT && (pcnt >= plen || (zero_cur_i && !mode_q)))
                  || (st == S_WAIT && pcnt >= plen);
  assign on_up     = (on_t >= ONMX) ? ONMX : on_t + 1'b1;
  assign on_dn     = (on_t <= ONMN) ? ONMN : on_t - 1'b1;
  assign on_nx     = !mode_q ? on_t : below_lo_i ? on_up : above_hi_i ? on_dn : on_t;
  assign hi_sat    = (hi_cnt >= HLIM) ? HLIM : hi_cnt + 1'b1;
  assign fall      = mode_q && above_hi_i && !below_lo_i && !force_act && (hi_sat >= HLIM);
  assign mode_nx   = force_act | below_lo_i | (mode_q & ~fall);
  assign hold_nx   = down_sel_i & vin_low_i;
  assign stretch   = below_lo_i & ~hold_nx;

  assign chg_on      = (st == S_CHG) || (st == S_HOLD);
  assign rect_on     = (st == S_RECT);
  assign hs_gate_o   = dir_q ? chg_on : rect_on;
  assign ls_gate_o   = dir_q ? rect_on : chg_on;
  assign mode_cont_o = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_DEADA;
      pcnt    <= '0;
      chg_len <= ONIN;
      plen    <= P_LAST;
      on_t    <= ONIN;
      hi_cnt  <= '0;
      frc_cnt <= '0;
      fsync   <= '0;
      mode_q  <= 1'b1;
      dir_q   <= 1'b0;
      hold_q  <= 1'b0;
    end else begin
      fsync   <= {fsync[0], force_cont_i};
      frc_cnt <= fsync[1] ? FRLD : (frc_cnt != '0) ? frc_cnt - 1'b1 : '0;
      if (decide) begin
        st      <= (mode_nx || hold_nx) ? S_DEADA : S_IDLE;
        pcnt    <= '0;
        on_t    <= on_nx;
        hi_cnt  <= (mode_q && above_hi_i && !below_lo_i && !fall) ? hi_sat : '0;
        mode_q  <= mode_nx;
        dir_q   <= down_sel_i;
        hold_q  <= hold_nx;
        chg_len <= stretch ? on_nx + STR : on_nx;
        plen    <= stretch ? P_LAST_S : P_LAST;
      end else begin
        if (force_act) mode_q <= 1'b1;
        case (st)
          S_IDLE:
            if (force_act || !above_hi_i) begin
              st      <= S_DEADA;
              pcnt    <= '0;
              chg_len <= on_t;
              plen    <= P_LAST;
            end
          S_DEADA: begin
            pcnt <= pcnt + 1'b1;
            st   <= hold_q ? S_HOLD : S_CHG;
          end
          S_CHG: begin
            pcnt <= pcnt + 1'b1;
            if (over_cur_i || pcnt >= chg_len) st <= S_DEADB;
          end
          S_DEADB: begin
            pcnt <= pcnt + 1'b1;
            st   <= S_RECT;
          end
          S_RECT: begin
            pcnt <= pcnt + 1'b1;
            if (zero_cur_i) st <= S_WAIT;
          end
          S_WAIT: pcnt <= pcnt + 1'b1;
          S_HOLD:
            if (!vin_low_i) begin
              st     <= S_DEADB;
              pcnt   <= chg_len + 1'b1;
              hold_q <= 1'b0;
            end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_gate_o && ls_gate_o)); // R1
  AST_GAP_HS_LS: assert property (@(posedge clk) disable iff (!rst_n)
    hs_gate_o |=> !ls_gate_o); // R1
  AST_GAP_LS_HS: assert property (@(posedge clk) disable iff (!rst_n)
    ls_gate_o |=> !hs_gate_o); // R1
  AST_OC_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHG && over_cur_i) |=> (st != S_CHG)); // R4
  AST_ZC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RECT && zero_cur_i) |=> (st != S_RECT)); // R5
  AST_ON_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (on_t >= ONMN) && (on_t <= ONMX)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && above_hi_i && !force_act) |=> (st == S_IDLE)); // R7
  AST_FORCE_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    force_act |=> mode_cont_o); // R8
  AST_HOLD_HS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_HOLD && vin_low_i) |=> (hs_gate_o && !ls_gate_o)); // R9
endmodule

// File: tb/tb_window_switch_ctrl.sv
module tb_window_switch_ctrl;
  localparam int CLK_P = 10;
  localparam int WD    = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic force_c = 1'b0, down = 1'b0, ahi = 1'b0, blo = 1'b0, oc = 1'b0, zc = 1'b0, vlow = 1'b0;
  logic hs, ls, mode;

  int total = 0, bad = 0, ovl = 0, mw = 0, on_m = 6;
  int q[$];
  bit mon_on = 1'b0, down_b = 1'b0, tog_en = 1'b0, done = 1'b0;
  logic ph = 1'b0, pl = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  window_switch_ctrl dut (
    .clk(clk), .rst_n(rst_n), .force_cont_i(force_c), .down_sel_i(down),
    .above_hi_i(ahi), .below_lo_i(blo), .over_cur_i(oc), .zero_cur_i(zc),
    .vin_low_i(vlow), .hs_gate_o(hs), .ls_gate_o(ls), .mode_cont_o(mode));

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic cg();
    return down_b ? hs : ls;
  endfunction

  // scoreboard monitor: charge pulse widths against the expected queue
  always @(negedge clk) begin
    if (mon_on) begin
      if (cg() === 1'b1) mw++;
      else if (mw != 0) begin
        if (q.size() == 0) check("R3 R6 unexpected charge pulse", mw, 0);
        else check("R2 R3 R6 R8 charge width", mw, q.pop_front());
        mw = 0;
      end
    end
  end

  // handover monitor (R1)
  always @(negedge clk) begin
    if (hs === 1'b1 && ls === 1'b1) ovl++;
    if (ph === 1'b1 && ls === 1'b1) ovl++;
    if (pl === 1'b1 && hs === 1'b1) ovl++;
    ph = hs;
    pl = ls;
  end

  initial begin : toggler
    int tc;
    tc = 0;
    forever begin
      @(negedge clk);
      if (tog_en) begin
        tc++;
        if (tc == 3) begin force_c = ~force_c; tc = 0; end
      end
    end
  end

  task automatic wait_chg_fall();
    logic p;
    p = cg();
    forever begin
      @(negedge clk);
      if (p === 1'b1 && cg() === 1'b0) break;
      p = cg();
    end
  endtask

  task automatic meas_w(input bit sel_hs, output int w);
    w = 0;
    while ((sel_hs ? hs : ls) !== 1'b0) @(negedge clk);
    while ((sel_hs ? hs : ls) !== 1'b1) @(negedge clk);
    while ((sel_hs ? hs : ls) === 1'b1) begin w++; @(negedge clk); end
  endtask

  task automatic meas_p(input bit sel_hs, output int p);
    bit seen_low;
    while ((sel_hs ? hs : ls) !== 1'b0) @(negedge clk);
    while ((sel_hs ? hs : ls) !== 1'b1) @(negedge clk);
    p = 0;
    seen_low = 0;
    forever begin
      @(negedge clk);
      p++;
      if ((sel_hs ? hs : ls) === 1'b0) seen_low = 1;
      if (seen_low && (sel_hs ? hs : ls) === 1'b1) break;
    end
  endtask

  // driver: set window flags after a charge pulse, push the next expected width
  task automatic cyc(input logic a, input logic b);
    int w;
    wait_chg_fall();
    ahi = a;
    blo = b;
    if (b) begin
      on_m = (on_m + 1 > 16) ? 16 : on_m + 1;
      w = on_m + 8;
    end else if (a) begin
      on_m = (on_m - 1 < 2) ? 2 : on_m - 1;
      w = on_m;
    end else w = on_m;
    q.push_back(w);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (WD) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin : main
    int w;
    repeat (3) @(negedge clk);
    check("R2 hs low in reset", int'(hs), 0);
    check("R2 ls low in reset", int'(ls), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 continuous after reset", int'(mode), 1);

    meas_w(1'b0, w);  check("R2 initial on-time pulse", w, 6);
    meas_p(1'b0, w);  check("R2 period length", w, 22);
    meas_w(1'b1, w);  check("R10 up-mode rectifier on hs", w, 14);

    wait_chg_fall();
    q.push_back(on_m);
    mon_on = 1'b1;
    cyc(1'b0, 1'b1);               // R3 stretched ramp
    cyc(1'b0, 1'b0);               // R3 back to normal
    for (int i = 0; i < 12; i++) cyc(1'b0, 1'b1);  // R6 saturate high
    cyc(1'b0, 1'b0);
    force_c = 1'b1;
    cyc(1'b0, 1'b0);
    cyc(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) cyc(1'b1, 1'b0);   // R8 held
    tog_en = 1'b1;
    for (int i = 0; i < 10; i++) cyc(1'b1, 1'b0);  // R8 toggling, R6 floor
    while (q.size() != 0) @(negedge clk);
    mon_on = 1'b0;
    check("R8 still continuous under force", int'(mode), 1);

    tog_en = 1'b0;
    force_c = 1'b0;
    repeat (150) @(negedge clk);
    check("R7 fell back to pulse mode", int'(mode), 0);
    w = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (hs === 1'b1 || ls === 1'b1) w++;
    end
    check("R7 no switching while above high limit", w, 0);

    zc = 1'b1;
    ahi = 1'b0;
    meas_w(1'b0, w);  check("R7 pulse uses frozen on-time", w, 2);
    meas_w(1'b1, w);  check("R5 rectifier cut at zero current", w, 1);
    check("R7 still pulse mode", int'(mode), 0);

    wait_chg_fall();
    blo = 1'b1;
    meas_w(1'b0, w);  check("R3 R7 stretched pulse on return", w, 10);
    blo = 1'b0;
    zc = 1'b0;
    check("R7 back in continuous mode", int'(mode), 1);
    meas_w(1'b0, w);  check("R3 normal pulse after stretch", w, 2);

    wait_chg_fall();
    oc = 1'b1;
    meas_w(1'b0, w);  check("R4 over-current ends charge", w, 1);
    oc = 1'b0;

    wait_chg_fall();
    down = 1'b1;
    vlow = 1'b1;
    repeat (60) @(negedge clk);
    check("R9 high side held on", int'(hs), 1);
    check("R9 low side held off", int'(ls), 0);
    vlow = 1'b0;
    down_b = 1'b1;
    meas_w(1'b1, w);  check("R10 down-mode charge on hs", w, 2);
    meas_w(1'b0, w);  check("R10 down-mode rectifier on ls", w, 18);

    check("R1 handovers with dead time", ovl, 0);
    summary();
  end
endmodule